// File: doc/BRIEF.md
# Task-State Save/Restore Sequencer

This block carries out the memory side of a hardware task switch for a 16-bit processor model. A task's state lives in a 22-word area of memory. When `start_i` is accepted, the block captures the live register values, the two area base addresses and the link request. It then writes the volatile part of the outgoing task's state into the outgoing area. Next it reads every word of the incoming area except the first, and loads those words into a context file that it drives out as `ctx_o`. When asked, it finally writes the outgoing task's selector into word 0 of the incoming area, so the new task can find its caller.

The area layout uses byte offsets from the area base, in steps of two. Offset 0 holds the back-link word. Offsets 2 to 12 hold three stack pointer and stack segment pairs, one pair per privilege level from 0 to 2. Offset 14 holds IP and offset 16 holds FLAGS. Offsets 18 to 32 hold AX, CX, DX, BX, SP, BP, SI and DI. Offsets 34 to 40 hold ES, CS, SS and DS. Offset 42 holds the local descriptor table selector. The link word, the stack pairs and the selector at 42 are static, so the save phase never writes them.

All memory traffic goes through one word-wide valid/ready port. The block raises `mem_valid_o` and keeps address, direction and write data fixed until it sees `mem_ready_i` high at a clock edge. A transfer completes at each edge where both are high. Read data is taken from `mem_rdata_i` in the same cycle as the read's ready. Holding ready low stalls the sequence for as long as it stays low. Nothing is lost while ready is low.

Top module: `tss_switch_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_valid_o` are low, and every word of `ctx_o` is zero.
- R2: The save phase writes 14 words, in ascending address order, to old base + 14, 16, …, 40. Word k of `live_regs_i` (bits 16k+15 down to 16k: IP, FLAGS, AX, CX, DX, BX, SP, BP, SI, DI, ES, CS, SS, DS for k = 0..13) goes to offset 14+2k. The value written is the value on the port in the cycle where start was accepted.
- R3: The block never writes offsets 0 to 12 or offset 42 of the old area.
- R4: The load phase reads new base + 2, 4, …, 42 in ascending order. No read is issued before the last save write has been accepted.
- R5: After the sequence, word j of `ctx_o` (bits 16j+15 down to 16j, j = 0..20) holds the data read from new base offset 2+2j.
- R6: When `link_en_i` is high at start, one write of `link_sel_i` to new base + 0 follows the last read. When it is low, no write reaches that word.
- R7: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_valid_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` stay unchanged in the next cycle.
- R8: `done_o` is high for exactly one cycle, in the cycle after the final transfer. `busy_o` is high from the cycle after start until and including that cycle, and low afterwards.
- R9: A start asserted while `busy_o` is high is ignored. The traffic and the result are those of the switch already under way.
- R10: Addresses are base plus offset, modulo 2^ADDR_W, so an area may wrap past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a switch; taken only when idle |
| old_base_i | input | ADDR_W | Byte base of the outgoing task area |
| new_base_i | input | ADDR_W | Byte base of the incoming task area |
| link_en_i | input | 1 | Write a back-link into the incoming area |
| link_sel_i | input | DATA_W | Selector of the outgoing task, used as the back-link |
| live_regs_i | input | 14*DATA_W | Live volatile registers, IP in word 0 to DS in word 13 |
| mem_valid_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address of the request |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | DATA_W | Read data, valid with ready on a read |
| ctx_o | output | 21*DATA_W | Reloaded context, offset 2 in word 0 to offset 42 in word 20 |
| busy_o | output | 1 | Switch in progress |
| done_o | output | 1 | One-cycle end-of-switch pulse |

## Verification
The bench builds the block with ADDR_W set to 10 and DATA_W kept at 16. With that setting, a 512-word memory model covers the whole address space. Every byte address then has a real backing word, and an incoming area can be placed to wrap past the top of memory, which exercises R10. The memory model alternates between ready always high and a pseudo-random ready. The random mode produces long stalls that hold requests in the middle of both the save phase and the load phase.

// File: rtl/tss_pkg.sv
package tss_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_SAVE = 3'd1,
    PH_LOAD = 3'd2,
    PH_LINK = 3'd3,
    PH_DONE = 3'd4
  } phase_e;

  // word indices within the 22-word area (byte offset = 2 * index)
  localparam int unsigned AREA_WORDS = 22;
  localparam int unsigned IDX_W      = 5;
  localparam int unsigned LINK_IDX   = 0;
  localparam int unsigned LOAD_FIRST = 1;
  localparam int unsigned LOAD_LAST  = 21;
  localparam int unsigned SAVE_FIRST = 7;
  localparam int unsigned SAVE_LAST  = 20;
  localparam int unsigned N_SAVE     = SAVE_LAST - SAVE_FIRST + 1;
  localparam int unsigned N_LOAD     = LOAD_LAST - LOAD_FIRST + 1;

endpackage

// File: rtl/tss_seq_fsm.sv
module tss_seq_fsm
  import tss_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 link_en_i,
  input  logic                 xfer_i,
  output phase_e               phase_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 cap_o,
  output logic                 busy_o,
  output logic                 done_o
);

  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic             link_q;

  assign cap_o   = (phase_q == PH_IDLE) && start_i;
  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = (phase_q == PH_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      link_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_SAVE;
            idx_q   <= IDX_W'(SAVE_FIRST);
            link_q  <= link_en_i;
          end
        end
        PH_SAVE: begin
          if (xfer_i) begin
            if (idx_q == IDX_W'(SAVE_LAST)) begin
              phase_q <= PH_LOAD;
              idx_q   <= IDX_W'(LOAD_FIRST);
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        PH_LOAD: begin
          if (xfer_i) begin
            if (idx_q == IDX_W'(LOAD_LAST)) begin
              phase_q <= link_q ? PH_LINK : PH_DONE;
              idx_q   <= IDX_W'(LINK_IDX);
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        PH_LINK: begin
          if (xfer_i) phase_q <= PH_DONE;
        end
        PH_DONE: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  assert_load_after_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOAD) |=> (phase_q != PH_SAVE));

endmodule

// File: rtl/tss_port_drv.sv
module tss_port_drv
  import tss_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_i,
  input  logic                     start_i,
  input  logic                     busy_i,
  input  phase_e                   phase_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [ADDR_W-1:0]        old_base_i,
  input  logic [ADDR_W-1:0]        new_base_i,
  input  logic [DATA_W-1:0]        link_sel_i,
  input  logic [N_SAVE*DATA_W-1:0] live_regs_i,
  input  logic                     mem_ready_i,
  output logic                     mem_valid_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [DATA_W-1:0]        mem_wdata_o
);

  localparam int unsigned SEL_W = $clog2(N_SAVE);

  logic [ADDR_W-1:0] old_q, new_q;
  logic [DATA_W-1:0] link_q;
  logic [DATA_W-1:0] snap_q [N_SAVE];
  logic [IDX_W-1:0]  save_sel;
  logic [ADDR_W-1:0] base_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q  <= '0;
      new_q  <= '0;
      link_q <= '0;
    end else if (cap_i) begin
      old_q  <= old_base_i;
      new_q  <= new_base_i;
      link_q <= link_sel_i;
    end
  end

  for (genvar k = 0; k < N_SAVE; k++) begin : g_snap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     snap_q[k] <= '0;
      else if (cap_i) snap_q[k] <= live_regs_i[k*DATA_W +: DATA_W];
    end
  end

  assign save_sel    = idx_i - IDX_W'(SAVE_FIRST);
  assign base_sel    = (phase_i == PH_SAVE) ? old_q : new_q;
  assign mem_valid_o = (phase_i == PH_SAVE) || (phase_i == PH_LOAD) || (phase_i == PH_LINK);
  assign mem_we_o    = (phase_i == PH_SAVE) || (phase_i == PH_LINK);
  assign mem_addr_o  = base_sel + ADDR_W'({idx_i, 1'b0});

  always_comb begin
    mem_wdata_o = '0;
    if (phase_i == PH_LINK)
      mem_wdata_o = link_q;
    else if (phase_i == PH_SAVE && save_sel < IDX_W'(N_SAVE))
      mem_wdata_o = snap_q[save_sel[SEL_W-1:0]];
  end

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_we_o) && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && start_i) |=> ($stable(old_q) && $stable(new_q) && $stable(link_q)));

  assert_no_static_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && mem_we_o && phase_i != PH_LINK) |->
      ((mem_addr_o - old_q) >= ADDR_W'(14) && (mem_addr_o - old_q) <= ADDR_W'(40)));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> !mem_valid_o);

endmodule

// File: rtl/tss_ctx_file.sv
module tss_ctx_file
  import tss_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  phase_e                   phase_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic                     xfer_i,
  input  logic [DATA_W-1:0]        rdata_i,
  output logic [N_LOAD*DATA_W-1:0] ctx_o
);

  logic [IDX_W-1:0] wsel;
  assign wsel = idx_i - IDX_W'(LOAD_FIRST);

  for (genvar j = 0; j < N_LOAD; j++) begin : g_ctx
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (xfer_i && phase_i == PH_LOAD && wsel == IDX_W'(j))
        word_q <= rdata_i;
    end
    assign ctx_o[j*DATA_W +: DATA_W] = word_q;
  end

  assert_ctx_only_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i != PH_LOAD) |=> $stable(ctx_o));

endmodule

// File: rtl/tss_switch_seq.sv
module tss_switch_seq
  import tss_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [ADDR_W-1:0]        old_base_i,
  input  logic [ADDR_W-1:0]        new_base_i,
  input  logic                     link_en_i,
  input  logic [DATA_W-1:0]        link_sel_i,
  input  logic [N_SAVE*DATA_W-1:0] live_regs_i,
  output logic                     mem_valid_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [DATA_W-1:0]        mem_wdata_o,
  input  logic                     mem_ready_i,
  input  logic [DATA_W-1:0]        mem_rdata_i,
  output logic [N_LOAD*DATA_W-1:0] ctx_o,
  output logic                     busy_o,
  output logic                     done_o
);

  phase_e           phase;
  logic [IDX_W-1:0] idx;
  logic             cap;
  logic             xfer;

  assign xfer = mem_valid_o && mem_ready_i;

  tss_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .link_en_i (link_en_i),
    .xfer_i    (xfer),
    .phase_o   (phase),
    .idx_o     (idx),
    .cap_o     (cap),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  tss_port_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_i       (cap),
    .start_i     (start_i),
    .busy_i      (busy_o),
    .phase_i     (phase),
    .idx_i       (idx),
    .old_base_i  (old_base_i),
    .new_base_i  (new_base_i),
    .link_sel_i  (link_sel_i),
    .live_regs_i (live_regs_i),
    .mem_ready_i (mem_ready_i),
    .mem_valid_o (mem_valid_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  tss_ctx_file #(.DATA_W(DATA_W)) u_ctx (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (phase),
    .idx_i   (idx),
    .xfer_i  (xfer),
    .rdata_i (mem_rdata_i),
    .ctx_o   (ctx_o)
  );

  assert_done_no_traffic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_valid_o);

endmodule

// File: tb/tss_switch_seq_tb_top.sv
module tss_switch_seq_tb_top;

  localparam int AW = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] old_base = '0, new_base = '0;
  logic          link_en = 1'b0;
  logic [DW-1:0] link_sel = '0;
  logic [14*DW-1:0] live = '0;
  logic          mem_valid, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [21*DW-1:0] ctx;
  logic          busy, done;

  always #10 clk = ~clk;  // 50 MHz

  tss_switch_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .old_base_i(old_base),
    .new_base_i(new_base), .link_en_i(link_en), .link_sel_i(link_sel),
    .live_regs_i(live), .mem_valid_o(mem_valid), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata), .ctx_o(ctx), .busy_o(busy), .done_o(done)
  );

  logic [DW-1:0] mem [512];
  assign mem_rdata = mem[mem_addr[AW-1:1]];

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; bit is_link; } wr_t;
  wr_t           exp_wr[$];
  logic [AW-1:0] exp_rd[$];
  int            save_pending = 0;
  int            errors = 0, checks = 0;
  bit            rnd_mode = 1'b0;
  logic [15:0]   lfsr = 16'hACE1;
  logic          rdy = 1'b1;
  bit            stall_prev = 1'b0;
  logic [AW-1:0] st_a;
  logic [DW-1:0] st_d;
  logic          st_we;

  assign mem_ready = rdy;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and monitor: pick ready, then resolve the transfer at the coming edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)
        check(mem_valid && mem_we == st_we && mem_addr == st_a && mem_wdata == st_d,
              "R7 stall hold", {mem_we, mem_addr, mem_wdata}, {st_we, st_a, st_d});
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy  = rnd_mode ? (lfsr[0] & lfsr[3]) : 1'b1;
      stall_prev = mem_valid && !rdy;
      st_a = mem_addr; st_d = mem_wdata; st_we = mem_we;
      if (mem_valid && rdy) begin
        if (mem_we) begin
          if (exp_wr.size() == 0) begin
            check(1'b0, "R3/R6/R9 unexpected write", mem_addr, 0);
          end else begin
            wr_t e;
            e = exp_wr.pop_front();
            if (e.is_link) begin
              check(exp_rd.size() == 0, "R6 link after loads", exp_rd.size(), 0);
              check(mem_addr == e.a && mem_wdata == e.d, "R6 link write",
                    {mem_addr, mem_wdata}, {e.a, e.d});
            end else begin
              save_pending--;
              check(mem_addr == e.a && mem_wdata == e.d, "R2 save write",
                    {mem_addr, mem_wdata}, {e.a, e.d});
            end
          end
          mem[mem_addr[AW-1:1]] = mem_wdata;
        end else begin
          check(save_pending == 0, "R4 read before save done", save_pending, 0);
          if (exp_rd.size() == 0) check(1'b0, "R4/R9 unexpected read", mem_addr, 0);
          else begin
            logic [AW-1:0] ea;
            ea = exp_rd.pop_front();
            check(mem_addr == ea, "R4 read address", mem_addr, ea);
          end
        end
      end
    end
  end

  function automatic logic [DW-1:0] live_word(int k, int seed);
    return DW'(seed * 16'h0101 + k * 16'h0111 + 16'h0F00);
  endfunction

  task automatic run_switch(input logic [AW-1:0] ob, input logic [AW-1:0] nb,
                            input bit len, input logic [DW-1:0] lsel,
                            input int seed, input bit interfere);
    logic [DW-1:0] exp_ctx [21];
    logic [DW-1:0] stat_before [8];
    logic [DW-1:0] link_before;
    int            wait_cnt;
    for (int k = 0; k < 14; k++) begin
      live[k*DW +: DW] = live_word(k, seed);
      exp_wr.push_back('{a: AW'(ob + AW'(14 + 2*k)), d: live_word(k, seed), is_link: 1'b0});
      save_pending++;
    end
    for (int j = 0; j < 21; j++) begin
      logic [AW-1:0] a;
      a = AW'(nb + AW'(2 + 2*j));   // R10: modulo address space
      exp_rd.push_back(a);
      exp_ctx[j] = mem[a[AW-1:1]];
    end
    if (len) exp_wr.push_back('{a: nb, d: lsel, is_link: 1'b1});
    for (int s = 0; s < 7; s++) begin
      logic [AW-1:0] a;
      a = AW'(ob + AW'(2*s));
      stat_before[s] = mem[a[AW-1:1]];
    end
    begin
      logic [AW-1:0] a;
      a = AW'(ob + AW'(42));
      stat_before[7] = mem[a[AW-1:1]];
    end
    link_before = mem[nb[AW-1:1]];

    @(negedge clk);
    old_base = ob; new_base = nb; link_en = len; link_sel = lsel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    live = ~live;  // R2: later changes must not reach memory
    check(busy == 1'b1, "R8 busy after start", busy, 1);
    if (interfere) begin
      @(negedge clk); @(negedge clk);
      old_base = AW'(ob + 10'h100); new_base = AW'(nb + 10'h40);
      link_en = 1'b1; link_sel = 16'hDEAD; start = 1'b1;   // R9
      @(negedge clk);
      start = 1'b0;
    end
    wait_cnt = 0;
    while (!done && wait_cnt < 2000) begin
      @(negedge clk);
      wait_cnt++;
    end
    check(done == 1'b1 && busy == 1'b1, "R8 done with busy", {done, busy}, 2'b11);
    check(exp_wr.size() == 0 && exp_rd.size() == 0, "R2/R4/R6 all traffic seen",
          exp_wr.size() + exp_rd.size(), 0);
    for (int j = 0; j < 21; j++)
      check(ctx[j*DW +: DW] == exp_ctx[j], "R5 context word", ctx[j*DW +: DW], exp_ctx[j]);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R8 single-cycle done", {done, busy}, 2'b00);
    for (int s = 0; s < 7; s++) begin
      logic [AW-1:0] a;
      a = AW'(ob + AW'(2*s));
      check(mem[a[AW-1:1]] == stat_before[s], "R3 static word untouched",
            mem[a[AW-1:1]], stat_before[s]);
    end
    begin
      logic [AW-1:0] a;
      a = AW'(ob + AW'(42));
      check(mem[a[AW-1:1]] == stat_before[7], "R3 selector word untouched",
            mem[a[AW-1:1]], stat_before[7]);
    end
    if (!len)
      check(mem[nb[AW-1:1]] == link_before, "R6 no link write", mem[nb[AW-1:1]], link_before);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(!mem_valid && !busy, "R9 quiet after done", {mem_valid, busy}, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = DW'(16'hC000 + i * 7);
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_valid, "R1 reset outputs", {busy, done, mem_valid}, 0);
    check(ctx == '0, "R1 reset context", ctx[DW-1:0], 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_valid, "R1 idle after reset", {busy, mem_valid}, 0);

    rnd_mode = 1'b0;
    run_switch(10'h040, 10'h100, 1'b1, 16'h0023, 1, 1'b0);   // R2 R4 R5 R6
    rnd_mode = 1'b1;
    run_switch(10'h200, 10'h080, 1'b0, 16'h0011, 2, 1'b0);   // R7 R3 R6
    run_switch(10'h140, 10'h1C0, 1'b1, 16'h0042, 3, 1'b1);   // R9
    rnd_mode = 1'b0;
    run_switch(10'h380, 10'h3F0, 1'b1, 16'h0077, 4, 1'b0);   // R10 wrap
    rnd_mode = 1'b1;
    run_switch(10'h100, 10'h040, 1'b0, 16'h0005, 5, 1'b1);   // R9 with stalls

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule